// File: doc/BRIEF.md
# Analog I/O Card Register Front-End

This block is the device side of a small analog input/output card on a byte- and word-wide I/O bus. It claims a window of sixteen consecutive byte addresses at a parameterised base. Inside that window it holds the setup for the analog input: a channel number, a gain code, a polarity bit and a trigger-mode byte. It also holds two 16-bit output words for the digital-to-analog converters and a four-in, four-out digital port.

A host writes any value to window offset 0 to start a conversion. A busy flag in the status byte stays set while the conversion runs. When the flag clears, a 16-bit read at offset 0 returns the result. The converter is modelled by a timer of fixed length. When the timer expires, the block takes one 16-bit code from a bank of sample inputs and scales it by the gain and polarity that were in force when the conversion started.

Top module: `daq_front`

## Requirements
- R1: `io_hit` is 1 only when `io_rd` or `io_wr` is high and `io_addr` lies in BASE..BASE+15. A read outside the window returns 0. A write outside the window changes no register.
- R2: A write to offset 0 while idle starts a conversion. Bit 7 of the status byte at offset 8 reads 1 from the next cycle on, for exactly CONV_CLKS cycles, and then reads 0.
- R3: A write to offset 0 during a conversion is ignored. The running conversion ends at the time it would have ended without that write.
- R4: A word read (`io_wide`=1) at offset 0 returns the 16-bit result. Byte reads at offsets 0 and 1 return its low and high byte in bits 7:0.
- R5: The result scales the sample by 2^g, where g is the gain code (0 to 3). In unipolar mode (config bit 2 = 1) the sample is unsigned and saturates at 0xFFFF. In bipolar mode (bit 2 = 0) the sample is two's complement, saturates to -32768..32767, and is returned in offset binary (sign bit inverted). The gain and polarity used are the ones held when the conversion started.
- R6: The sampled channel is the low nibble of the channel byte at offset 2. When `diff_strap`=1 only its low 3 bits are used. Status bit 5 equals `diff_strap`.
- R7: The channel byte (offset 2), the trigger byte (offset 9) and config bits 2:0 (offset 11) read back as written. `gain_sel` shows config bits 1:0 and `unipolar_sel` shows config bit 2.
- R8: A word write at offset 4 or 6 loads output word 0 or 1 (`dac_out` bits 15:0 or 31:16). A byte write at an even offset loads the low byte of that word and a byte write at the following odd offset loads its high byte. Each word reads back at its offsets.
- R9: A read at offset 3 returns `dig_in` in bits 3:0. A write at offset 3 drives bits 3:0 onto `dig_out`.
- R10: Reset clears both output words, the config, trigger, channel and digital-output registers, the result, and the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | AW | Bus byte address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| io_rdata | output | 16 | Read data, combinational, 0 when not selected |
| io_hit | output | 1 | Access falls inside the window |
| diff_strap | input | 1 | Differential-input strap |
| sample_bus | input | 256 | Sixteen 16-bit sample codes, channel n at bits 16n+15:16n |
| dig_in | input | 4 | Digital inputs |
| dig_out | output | 4 | Digital outputs |
| dac_out | output | 32 | Two 16-bit converter output words |
| gain_sel | output | 2 | Current gain code |
| unipolar_sel | output | 1 | Current polarity bit |

## Verification
The conversion path is tried with random samples, channels, gain codes and polarities. Samples near full scale and large gains tell correct saturation apart from wrap-around. Both polarities at the same code tell the offset-binary flip apart from a plain copy. Directed cases follow. A second start issued mid-conversion exposes a timer that reloads. A config write made mid-conversion exposes scaling that is not latched at the start. A channel byte with unequal nibbles and bit 3 set, tried with the strap on and off, exposes wrong channel masking.

// File: rtl/daq_pkg.sv
package daq_pkg;

    localparam int SMP_W     = 16;
    localparam int NCH       = 16;
    localparam int CH_W      = $clog2(NCH);
    localparam int DAC_COUNT = 2;

    localparam logic [3:0] OFS_RES_LO = 4'd0;
    localparam logic [3:0] OFS_RES_HI = 4'd1;
    localparam logic [3:0] OFS_CHAN   = 4'd2;
    localparam logic [3:0] OFS_DIO    = 4'd3;
    localparam logic [3:0] OFS_DAC0   = 4'd4;
    localparam logic [3:0] OFS_STAT   = 4'd8;
    localparam logic [3:0] OFS_TRIG   = 4'd9;
    localparam logic [3:0] OFS_CFG    = 4'd11;

    typedef enum logic {CV_IDLE = 1'b0, CV_RUN = 1'b1} conv_state_t;

    typedef struct packed {
        logic       unipolar;
        logic [1:0] gain;
    } cfg_t;

    typedef struct packed {
        logic [CH_W-1:0] ch;
        cfg_t            cfg;
    } conv_req_t;

    function automatic logic [SMP_W-1:0] scale_sample(
        input logic [SMP_W-1:0] raw,
        input cfg_t             cfg
    );
        logic [SMP_W+2:0]        u;
        logic signed [SMP_W+2:0] s;
        logic [SMP_W-1:0]        r;
        if (cfg.unipolar) begin
            u = {3'b000, raw} << cfg.gain;
            r = (u[SMP_W+2:SMP_W] != 3'b000) ? '1 : u[SMP_W-1:0];
        end else begin
            s = {{3{raw[SMP_W-1]}}, raw} << cfg.gain;
            if (s > 19'sd32767)
                r = 16'h7FFF;
            else if (s < -19'sd32768)
                r = 16'h8000;
            else
                r = s[SMP_W-1:0];
            r = r ^ 16'h8000;
        end
        return r;
    endfunction

endpackage

// File: rtl/daq_decode.sv
module daq_decode #(
    parameter int          AW   = 16,
    parameter logic [31:0] BASE = 32'h300
) (
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output logic          hit,
    output logic [3:0]    ofs
);
    localparam logic [AW-1:0] BASE_V = BASE[AW-1:0];

    logic [AW-1:0] diff;

    always_comb begin
        diff = addr - BASE_V;
        ofs  = diff[3:0];
        hit  = (diff < AW'(16)) && (rd || wr);
    end

endmodule

// File: rtl/daq_conv.sv
module daq_conv
    import daq_pkg::*;
#(
    parameter int CONV_CLKS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  conv_req_t            req,
    input  logic [NCH*SMP_W-1:0] sample_bus,
    output logic                 busy,
    output logic [SMP_W-1:0]     result
);
    localparam int CW = $clog2(CONV_CLKS + 1);

    conv_state_t      state;
    logic [CW-1:0]    cnt;
    conv_req_t        held;
    logic [SMP_W-1:0] smp [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_unpack
        assign smp[i] = sample_bus[i*SMP_W +: SMP_W];
    end

    assign busy = (state == CV_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CV_IDLE;
            cnt    <= '0;
            held   <= '0;
            result <= '0;
        end else begin
            case (state)
                CV_IDLE: if (start) begin
                    state <= CV_RUN;
                    cnt   <= CW'(CONV_CLKS - 1);
                    held  <= req;
                end
                CV_RUN: begin
                    if (cnt == '0) begin
                        state  <= CV_IDLE;
                        result <= scale_sample(smp[held.ch], held.cfg);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= CV_IDLE;
            endcase
        end
    end

    // R2
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R2
    expiry_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == '0) |=> !busy);

    // R3
    no_reload_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

    // R5
    result_stable_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));

endmodule

// File: rtl/daq_word_reg.sv
module daq_word_reg (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [7:0]  lo_in,
    input  logic [7:0]  hi_in,
    output logic [15:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (wr_lo) q[7:0]  <= lo_in;
            if (wr_hi) q[15:8] <= hi_in;
        end
    end

    // R8
    untouched_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_lo && !wr_hi) |=> $stable(q));

endmodule

// File: rtl/daq_front.sv
module daq_front
    import daq_pkg::*;
#(
    parameter int          AW        = 16,
    parameter logic [31:0] BASE      = 32'h300,
    parameter int          CONV_CLKS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [AW-1:0]            io_addr,
    input  logic                     io_rd,
    input  logic                     io_wr,
    input  logic                     io_wide,
    input  logic [15:0]              io_wdata,
    output logic [15:0]              io_rdata,
    output logic                     io_hit,
    input  logic                     diff_strap,
    input  logic [NCH*SMP_W-1:0]     sample_bus,
    input  logic [3:0]               dig_in,
    output logic [3:0]               dig_out,
    output logic [DAC_COUNT*16-1:0]  dac_out,
    output logic [1:0]               gain_sel,
    output logic                     unipolar_sel
);
    logic [3:0]       ofs;
    logic             wr_hit;
    logic [7:0]       chan_q;
    logic [7:0]       trig_q;
    cfg_t             cfg_q;
    logic [3:0]       dout_q;
    logic             busy;
    logic [SMP_W-1:0] result;
    conv_req_t        req;
    logic [15:0]      dac_q [DAC_COUNT];
    logic [15:0]      rd_mux;
    logic [7:0]       hi_byte;

    daq_decode #(.AW(AW), .BASE(BASE)) u_dec (
        .addr (io_addr),
        .rd   (io_rd),
        .wr   (io_wr),
        .hit  (io_hit),
        .ofs  (ofs)
    );

    assign wr_hit  = io_hit && io_wr;
    assign hi_byte = io_wide ? io_wdata[15:8] : io_wdata[7:0];

    always_comb begin
        req.cfg = cfg_q;
        req.ch  = diff_strap ? {1'b0, chan_q[CH_W-2:0]} : chan_q[CH_W-1:0];
    end

    daq_conv #(.CONV_CLKS(CONV_CLKS)) u_conv (
        .clk        (clk),
        .rst        (rst),
        .start      (wr_hit && ofs == OFS_RES_LO),
        .req        (req),
        .sample_bus (sample_bus),
        .busy       (busy),
        .result     (result)
    );

    for (genvar i = 0; i < DAC_COUNT; i++) begin : g_dac
        localparam logic [3:0] LO = 4'(OFS_DAC0 + 2 * i);
        localparam logic [3:0] HI = 4'(OFS_DAC0 + 2 * i + 1);
        daq_word_reg u_word (
            .clk   (clk),
            .rst   (rst),
            .wr_lo (wr_hit && ofs == LO),
            .wr_hi (wr_hit && ((ofs == LO && io_wide) || (ofs == HI && !io_wide))),
            .lo_in (io_wdata[7:0]),
            .hi_in (hi_byte),
            .q     (dac_q[i])
        );
        assign dac_out[i*16 +: 16] = dac_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
            trig_q <= '0;
            cfg_q  <= '0;
            dout_q <= '0;
        end else if (wr_hit) begin
            case (ofs)
                OFS_CHAN: chan_q <= io_wdata[7:0];
                OFS_TRIG: trig_q <= io_wdata[7:0];
                OFS_CFG:  cfg_q  <= cfg_t'(io_wdata[2:0]);
                OFS_DIO:  dout_q <= io_wdata[3:0];
                default: ;
            endcase
        end
    end

    assign dig_out      = dout_q;
    assign gain_sel     = cfg_q.gain;
    assign unipolar_sel = cfg_q.unipolar;

    always_comb begin
        rd_mux = '0;
        case (ofs)
            OFS_RES_LO: rd_mux = io_wide ? result : {8'h00, result[7:0]};
            OFS_RES_HI: rd_mux = {8'h00, result[15:8]};
            OFS_CHAN:   rd_mux = {8'h00, chan_q};
            OFS_DIO:    rd_mux = {12'h000, dig_in};
            OFS_STAT:   rd_mux = {8'h00, busy, 1'b0, diff_strap, 5'b00000};
            OFS_TRIG:   rd_mux = {8'h00, trig_q};
            OFS_CFG:    rd_mux = {13'h0000, cfg_q};
            default: begin
                for (int i = 0; i < DAC_COUNT; i++) begin
                    if (ofs == 4'(OFS_DAC0 + 2 * i))
                        rd_mux = io_wide ? dac_q[i] : {8'h00, dac_q[i][7:0]};
                    else if (ofs == 4'(OFS_DAC0 + 2 * i + 1))
                        rd_mux = {8'h00, dac_q[i][15:8]};
                end
            end
        endcase
    end

    assign io_rdata = (io_hit && io_rd) ? rd_mux : '0;

    // R1
    outside_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !io_hit) |=> ($stable(dac_out) && $stable(dig_out) &&
                                $stable(gain_sel) && $stable(unipolar_sel)));

    // R1
    outside_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !io_hit |-> io_rdata == '0);

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (dac_out == '0 && dig_out == 4'h0 && !busy &&
                 gain_sel == 2'b00 && !unipolar_sel));

endmodule

// File: tb/daq_front_test.sv
module daq_front_test;
    localparam int          C    = 8;
    localparam logic [15:0] BASE = 16'h0300;

    logic         clk = 1'b0;
    logic         rst;
    logic [15:0]  io_addr;
    logic         io_rd, io_wr, io_wide;
    logic [15:0]  io_wdata;
    logic [15:0]  io_rdata;
    logic         io_hit;
    logic         diff_strap;
    logic [255:0] sample_bus;
    logic [3:0]   dig_in, dig_out;
    logic [31:0]  dac_out;
    logic [1:0]   gain_sel;
    logic         unipolar_sel;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    daq_front #(.AW(16), .BASE({16'h0, BASE}), .CONV_CLKS(C)) uut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wide(io_wide), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit),
        .diff_strap(diff_strap), .sample_bus(sample_bus), .dig_in(dig_in),
        .dig_out(dig_out), .dac_out(dac_out), .gain_sel(gain_sel),
        .unipolar_sel(unipolar_sel)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input int raw, input int g, input int uni);
        int v;
        if (uni != 0) begin
            v = raw * (1 << g);
            if (v > 65535) v = 65535;
            return 16'(v);
        end
        v = (raw >= 32768) ? raw - 65536 : raw;
        v = v * (1 << g);
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return 16'(v + 32768);
    endfunction

    task automatic bus_wr(input logic [15:0] a, input logic [15:0] d, input logic w);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wide = w; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic w, output logic [15:0] d,
                          output logic h);
        @(negedge clk);
        io_addr = a; io_wide = w; io_rd = 1'b1;
        #1;
        d = io_rdata; h = io_hit;
        io_rd = 1'b0;
    endtask

    task automatic wait_idle(input int s, input string tag);
        logic [15:0] d;
        logic h;
        int f;
        f = -1;
        for (int k = 0; k < 4 * C + 8; k++) begin
            bus_rd(BASE + 16'd8, 1'b0, d, h);
            if (d[7] == 1'b0) begin
                f = cyc;
                break;
            end
        end
        check(tag, 32'(f - s), 32'(C));
    endtask

    task automatic run_conv(input logic [7:0] chreg, input int eff, input int g,
                            input int uni, input int raw, input logic strap);
        logic [15:0] d;
        logic h;
        int s;
        logic [15:0] exp;
        diff_strap = strap;
        for (int i = 0; i < 16; i++) sample_bus[i*16 +: 16] = 16'($urandom);
        sample_bus[eff*16 +: 16] = 16'(raw);
        bus_wr(BASE + 16'd11, 16'({uni[0], g[1:0]}), 1'b0);
        bus_wr(BASE + 16'd2, {8'h00, chreg}, 1'b0);
        bus_wr(BASE, 16'h0000, 1'b0);
        s = cyc;
        wait_idle(s, "R2 busy duration");
        exp = model(raw, g, uni);
        bus_rd(BASE, 1'b1, d, h);
        check("R5 scaled result (R4 word read)", {16'h0, d}, {16'h0, exp});
        bus_rd(BASE + 16'd1, 1'b0, d, h);
        check("R4 result high byte", {16'h0, d}, {24'h0, exp[15:8]});
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic h;
        int s;
        logic [15:0] exp;
        void'($urandom(1234));
        rst = 1'b1; io_addr = '0; io_rd = 0; io_wr = 0; io_wide = 0; io_wdata = '0;
        diff_strap = 0; sample_bus = '0; dig_in = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        check("R10 dac_out after reset", dac_out, 32'h0);
        check("R10 dig_out after reset", {28'h0, dig_out}, 32'h0);
        bus_rd(BASE + 16'd8, 1'b0, d, h);
        check("R10 busy after reset", {31'h0, d[7]}, 32'h0);
        bus_rd(BASE + 16'd11, 1'b0, d, h);
        check("R10 config after reset", {16'h0, d}, 32'h0);
        bus_rd(BASE, 1'b1, d, h);
        check("R10 result after reset", {16'h0, d}, 32'h0);

        // R1 decode window
        bus_rd(BASE + 16'd15, 1'b0, d, h);
        check("R1 hit at top of window", {31'h0, h}, 32'h1);
        bus_rd(BASE - 16'd1, 1'b0, d, h);
        check("R1 no hit below window", {15'h0, h, d}, 32'h0);
        bus_wr(BASE + 16'd20, 16'hBEEF, 1'b1);
        bus_wr(BASE + 16'd16 + 16'd3, 16'h000F, 1'b0);
        check("R1 outside write no effect dac", dac_out, 32'h0);
        check("R1 outside write no effect dio", {28'h0, dig_out}, 32'h0);

        // R9 digital port
        dig_in = 4'hA;
        bus_rd(BASE + 16'd3, 1'b0, d, h);
        check("R9 digital inputs", {16'h0, d}, 32'h000A);
        bus_wr(BASE + 16'd3, 16'h00F5, 1'b0);
        check("R9 digital outputs", {28'h0, dig_out}, 32'h5);

        // R7 register readback
        bus_wr(BASE + 16'd9, 16'h00C3, 1'b0);
        bus_rd(BASE + 16'd9, 1'b0, d, h);
        check("R7 trigger readback", {16'h0, d}, 32'h00C3);
        bus_wr(BASE + 16'd9, 16'h0000, 1'b0);
        bus_wr(BASE + 16'd11, 16'h00FE, 1'b0);
        bus_rd(BASE + 16'd11, 1'b0, d, h);
        check("R7 config readback", {16'h0, d}, 32'h0006);
        check("R7 gain/polarity pins", {29'h0, unipolar_sel, gain_sel}, 32'h6);
        bus_wr(BASE + 16'd2, 16'h005A, 1'b0);
        bus_rd(BASE + 16'd2, 1'b0, d, h);
        check("R7 channel readback", {16'h0, d}, 32'h005A);

        // R8 DAC words: word and byte writes
        bus_wr(BASE + 16'd4, 16'h1234, 1'b1);
        bus_wr(BASE + 16'd6, 16'hABCD, 1'b1);
        check("R8 dac word writes", dac_out, 32'hABCD1234);
        bus_wr(BASE + 16'd7, 16'h0077, 1'b0);
        bus_wr(BASE + 16'd4, 16'h0099, 1'b0);
        check("R8 dac byte writes", dac_out, 32'h77CD1299);
        bus_rd(BASE + 16'd6, 1'b1, d, h);
        check("R8 dac word readback", {16'h0, d}, 32'h77CD);
        bus_rd(BASE + 16'd5, 1'b0, d, h);
        check("R8 dac high byte readback", {16'h0, d}, 32'h0012);

        // R6 strap status and channel masking
        diff_strap = 1'b1;
        bus_rd(BASE + 16'd8, 1'b0, d, h);
        check("R6 strap status bit", {31'h0, d[5]}, 32'h1);
        run_conv(8'h9A, 2, 0, 1, 16'h1357, 1'b1);
        run_conv(8'h9A, 10, 0, 1, 16'h2468, 1'b0);

        // R5 saturation corners
        run_conv(8'h33, 3, 3, 1, 16'h4000, 1'b0);
        run_conv(8'h44, 4, 2, 0, 16'h7000, 1'b0);
        run_conv(8'h55, 5, 1, 0, 16'h8001, 1'b0);
        run_conv(8'h66, 6, 0, 0, 16'h0000, 1'b0);

        // R3 start while busy ignored
        sample_bus[7*16 +: 16] = 16'h0123;
        bus_wr(BASE + 16'd11, 16'h0005, 1'b0);
        bus_wr(BASE + 16'd2, 16'h0077, 1'b0);
        bus_wr(BASE, 16'h0000, 1'b0);
        s = cyc;
        bus_wr(BASE, 16'hFFFF, 1'b1);
        // R5 config change mid-conversion must not apply
        bus_wr(BASE + 16'd11, 16'h0000, 1'b0);
        wait_idle(s, "R3 restart ignored, end time unchanged");
        bus_rd(BASE, 1'b1, d, h);
        exp = model(16'h0123, 1, 1);
        check("R5 settings latched at start", {16'h0, d}, {16'h0, exp});

        // Random mix
        for (int n = 0; n < 40; n++) begin
            int ch, g, u, raw;
            logic [15:0] w0;
            ch = $urandom_range(0, 15);
            g = $urandom_range(0, 3);
            u = $urandom_range(0, 1);
            raw = $urandom_range(0, 65535);
            w0 = 16'($urandom);
            bus_wr(BASE + 16'd4 + 16'(2 * (n % 2)), w0, 1'b1);
            if (n % 2 == 0)
                check("R8 random dac0 word", {16'h0, dac_out[15:0]}, {16'h0, w0});
            else
                check("R8 random dac1 word", {16'h0, dac_out[31:16]}, {16'h0, w0});
            run_conv({4'(ch), 4'(ch)}, ch, g, u, raw, 1'b0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule